// File: doc/BRIEF.md
# Shared Serial Flash Pin Arbiter

This block sits between a serial flash device and an internal flash engine that normally owns the flash pins. Host software reaches the same pins through one control/status register. To drive them, software sets a request bit. The arbiter waits until the engine has no transaction in flight and then sets a grant bit. While the grant bit is set, the clock, chip-select and data-in pins take their levels directly from three register bits. Software produces a serial transfer by writing the register repeatedly and toggling the clock bit on each write.

The flash data-out pin can be read back through the register at any time. Three read-only flags show what kind of transaction the engine has started. A further flag tracks completion of writes on the host expansion path.

When software clears its request, the arbiter parks the pins in a safe state for a fixed number of cycles before it returns them to the engine. In the safe state the chip select is inactive (high) and the clock is low. The engine is told to hold off from the moment a request is seen until the park period ends.

Top module: `flash_pin_arbiter`

## Requirements
- R1: After reset the register reads with bit 9 set and every other bit clear, except bit 3, which reflects the data-out pin. The flash pins follow the engine's pin inputs and `eng_hold` is low.
- R2: Writing bit 4 = 1 while the engine is idle makes grant (bit 5) read 1 from the second rising clock edge after the write is presented. Grant then stays 1 for as long as bit 4 stays 1.
- R3: `eng_hold` is high whenever bit 4 reads 1. While `eng_busy` is high, grant is withheld and the pins keep following the engine. Grant reads 1 one clock edge after `eng_busy` falls.
- R4: While grant is 1, each register write immediately drives the pins: bit 0 sets `fl_sck`, bit 1 sets `fl_cs_n` (0 selects the flash, because the chip select is active low) and bit 2 sets `fl_si`.
- R5: Bit 3 always equals `fl_so`. Writing bit 3 has no effect.
- R6: Writing bit 4 = 0 while granted makes grant fall at the next edge. For the PARK_CYC cycles that follow, the pins read `fl_cs_n`=1, `fl_sck`=0 and `fl_si`=0, with `eng_hold` kept high. The engine then drives the pins again and `eng_hold` goes low.
- R7: While not granted and not parking, the pins follow `eng_sck`, `eng_cs_n` and `eng_si`. Register bits 0 to 2 keep their written values.
- R8: Writes to bits 5 to 9 and above bit 9 do not change those bits.
- R9: A start pulse on `eng_dev_erase`, `eng_sec_erase` or `eng_write` sets flag bit 6, 7 or 8 respectively at the next edge and clears the other two. The flags all clear at the first edge where `eng_busy` is low and no start pulse is present.
- R10: Bit 9 resets to 1. A `hx_wr_start` pulse clears it and a `hx_wr_done` pulse sets it. When both pulses arrive in the same cycle, `hx_wr_start` wins.
- R11: All register bits above bit 9 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| eng_busy | input | 1 | Engine transaction in progress |
| eng_sck | input | 1 | Engine flash clock |
| eng_cs_n | input | 1 | Engine flash chip select, active low |
| eng_si | input | 1 | Engine flash data in |
| eng_dev_erase | input | 1 | Engine device-erase start pulse |
| eng_sec_erase | input | 1 | Engine sector-erase start pulse |
| eng_write | input | 1 | Engine write start pulse |
| eng_hold | output | 1 | Engine must not start a new transaction |
| hx_wr_start | input | 1 | Host expansion write started |
| hx_wr_done | input | 1 | Host expansion write completed |
| fl_sck | output | 1 | Flash serial clock pin |
| fl_cs_n | output | 1 | Flash chip select pin, active low |
| fl_si | output | 1 | Flash serial data in pin |
| fl_so | input | 1 | Flash serial data out pin |

## Verification
The bench builds the block with DATA_W = 16 and PARK_CYC = 3. The 16-bit width leaves six bits above the flag field, so the read-as-zero behaviour and the write-ignore behaviour can both be observed on real storage-free bits. A three-cycle park window is long enough to sample the safe pin state several times before the engine regains the pins. It is also long enough to show that `eng_hold` spans the whole window, not only its first cycle.

// File: rtl/flash_pin_arbiter.sv
module flash_pin_arbiter #(
  parameter int DATA_W   = 32,
  parameter int PARK_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_sck,
  input  logic              eng_cs_n,
  input  logic              eng_si,
  input  logic              eng_dev_erase,
  input  logic              eng_sec_erase,
  input  logic              eng_write,
  output logic              eng_hold,
  input  logic              hx_wr_start,
  input  logic              hx_wr_done,
  output logic              fl_sck,
  output logic              fl_cs_n,
  output logic              fl_si,
  input  logic              fl_so
);

  localparam int CNT_W = (PARK_CYC > 1) ? $clog2(PARK_CYC) : 1;
  localparam int PAD_W = DATA_W - 10;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_GRANT, S_PARK} state_t;

  state_t         state;
  logic [CNT_W-1:0] park_cnt;
  logic [2:0]     ctl;
  logic           req;
  logic [2:0]     flg;
  logic           wdone;
  logic           grant;

  assign grant = (state == S_GRANT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= 3'b000;
      req <= 1'b0;
    end else if (reg_wr) begin
      ctl <= reg_wdata[2:0];
      req <= reg_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      park_cnt <= '0;
    end else begin
      case (state)
        S_IDLE:  if (req) state <= eng_busy ? S_WAIT : S_GRANT;
        S_WAIT:  if (!req) state <= S_IDLE;
                 else if (!eng_busy) state <= S_GRANT;
        S_GRANT: if (!req) begin
                   state    <= S_PARK;
                   park_cnt <= CNT_W'(PARK_CYC - 1);
                 end
        S_PARK:  if (park_cnt == '0) state <= S_IDLE;
                 else park_cnt <= park_cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flg <= 3'b000;
    else if (eng_dev_erase | eng_sec_erase | eng_write)
      flg <= {eng_write, eng_sec_erase, eng_dev_erase};
    else if (!eng_busy)
      flg <= 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wdone <= 1'b1;
    else if (hx_wr_start) wdone <= 1'b0;
    else if (hx_wr_done)  wdone <= 1'b1;
  end

  assign eng_hold = req | (state != S_IDLE);

  always_comb begin
    case (state)
      S_GRANT: {fl_si, fl_cs_n, fl_sck} = ctl;
      S_PARK:  {fl_si, fl_cs_n, fl_sck} = 3'b010;
      default: {fl_si, fl_cs_n, fl_sck} = {eng_si, eng_cs_n, eng_sck};
    endcase
  end

  assign reg_rdata = {{PAD_W{1'b0}}, wdone, flg, grant, req, fl_so, ctl};

endmodule

module flash_pin_arbiter_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              eng_busy,
  input logic              eng_hold,
  input logic              hx_wr_start,
  input logic              fl_sck,
  input logic              fl_cs_n,
  input logic              fl_si,
  input logic              fl_so
);

  assert_grant_needs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[5]) |-> ($past(reg_rdata[4]) && !$past(eng_busy)));

  assert_hold_while_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] |-> eng_hold);

  assert_grant_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[5] && reg_rdata[4]) |=> reg_rdata[5]);

  assert_pins_follow_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5] |-> (fl_sck == reg_rdata[0] && fl_cs_n == reg_rdata[1] && fl_si == reg_rdata[2]));

  assert_so_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[3] == fl_so);

  assert_park_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[5]) |-> (fl_cs_n && !fl_sck && eng_hold));

  assert_flags_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_rdata[8:6]));

  assert_wdone_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hx_wr_start |=> !reg_rdata[9]);

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:10] == '0);

endmodule

bind flash_pin_arbiter flash_pin_arbiter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
  .eng_hold(eng_hold), .hx_wr_start(hx_wr_start), .fl_sck(fl_sck),
  .fl_cs_n(fl_cs_n), .fl_si(fl_si), .fl_so(fl_so)
);

// File: tb/tb_flash_pin_arbiter.sv
module tb_flash_pin_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int PC = 3;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic eng_busy = 0, eng_sck = 1, eng_cs_n = 0, eng_si = 1;
  logic eng_dev_erase = 0, eng_sec_erase = 0, eng_write = 0, eng_hold;
  logic hx_wr_start = 0, hx_wr_done = 0;
  logic fl_sck, fl_cs_n, fl_si, fl_so = 0;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pin_arbiter #(.DATA_W(DW), .PARK_CYC(PC)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_busy(eng_busy), .eng_sck(eng_sck), .eng_cs_n(eng_cs_n), .eng_si(eng_si),
    .eng_dev_erase(eng_dev_erase), .eng_sec_erase(eng_sec_erase), .eng_write(eng_write),
    .eng_hold(eng_hold), .hx_wr_start(hx_wr_start), .hx_wr_done(hx_wr_done),
    .fl_sck(fl_sck), .fl_cs_n(fl_cs_n), .fl_si(fl_si), .fl_so(fl_so));

  // entry: [3] fl_so level, [2:0] {si, cs_n, sck} written while granted
  localparam logic [3:0] VEC [8] = '{4'b0000, 4'b1001, 4'b0010, 4'b1011,
                                     4'b0100, 4'b1101, 4'b0110, 4'b1111};

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] v);
    reg_wr = 1; reg_wdata = v; tick(); reg_wr = 0;
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pins();
    return {{(DW-4){1'b0}}, eng_hold, fl_si, fl_cs_n, fl_sck};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1;
    // R1 R11 reset state
    chk("R1 reset rdata", reg_rdata, 16'h0200);
    chk("R1 R7 reset pins follow engine", pins(), 16'h0005);

    // R2 request with engine idle
    wr(16'h0010);
    chk("R2 grant not yet", reg_rdata, 16'h0210);
    chk("R3 hold while request", pins(), 16'h000D);
    tick();
    chk("R2 grant set", reg_rdata, 16'h0230);

    // R4 R5 vector walk
    foreach (VEC[i]) begin
      fl_so = VEC[i][3];
      wr({11'b0, 1'b1, 1'b0, VEC[i][2:0]});
      chk("R4 pins from register", pins(), {12'b0, 1'b1, VEC[i][2:0]});
      chk("R5 R2 readback", reg_rdata, {6'b0, 1'b1, 3'b000, 1'b1, 1'b1, VEC[i][3], VEC[i][2:0]});
    end
    fl_so = 0;

    // R8 R11 read-only and upper bits ignore writes; R5 bit 3 write ignored
    wr(16'hFFF8);
    chk("R8 R11 read-only bits", reg_rdata, 16'h0230);
    fl_so = 1; #1;
    chk("R5 so tracks pin", reg_rdata, 16'h0238);
    fl_so = 0;

    // R6 release and park
    wr(16'h0015);
    wr(16'h0005);
    chk("R6 grant held until edge", reg_rdata, 16'h0225);
    chk("R6 pins still register", pins(), 16'h000D);
    for (int k = 0; k < PC; k++) begin
      tick();
      chk("R6 parked pins", pins(), 16'h000A);
      chk("R6 grant clear", reg_rdata, 16'h0205);
    end
    tick();
    chk("R6 R7 engine regains pins", pins(), 16'h0005);
    eng_sck = 0; eng_cs_n = 1; eng_si = 0; #1;
    chk("R7 pins follow engine", pins(), 16'h0002);
    chk("R7 register bits kept", reg_rdata, 16'h0205);

    // R3 busy engine defers grant
    eng_busy = 1;
    wr(16'h0010);
    repeat (4) tick();
    chk("R3 grant withheld", reg_rdata, 16'h0210);
    chk("R3 engine keeps pins hold high", pins(), 16'h000A);
    eng_busy = 0;
    tick();
    chk("R3 grant after idle", reg_rdata, 16'h0230);
    wr(16'h0002);
    repeat (PC + 1) tick();
    chk("R6 released", reg_rdata, 16'h0202);

    // R9 status flags
    eng_busy = 1; eng_sec_erase = 1;
    tick(); eng_sec_erase = 0;
    chk("R9 sector flag", reg_rdata, 16'h0282);
    tick();
    chk("R9 flag held while busy", reg_rdata, 16'h0282);
    eng_write = 1; tick(); eng_write = 0;
    chk("R9 write flag replaces", reg_rdata, 16'h0302);
    eng_dev_erase = 1; tick(); eng_dev_erase = 0;
    chk("R9 device flag", reg_rdata, 16'h0242);
    eng_busy = 0; tick();
    chk("R9 flags clear when idle", reg_rdata, 16'h0202);

    // R10 write-done flag
    hx_wr_start = 1; tick(); hx_wr_start = 0;
    chk("R10 start clears", reg_rdata, 16'h0002);
    tick();
    chk("R10 stays clear", reg_rdata, 16'h0002);
    hx_wr_done = 1; tick(); hx_wr_done = 0;
    chk("R10 done sets", reg_rdata, 16'h0202);
    hx_wr_start = 1; hx_wr_done = 1; tick(); hx_wr_start = 0; hx_wr_done = 0;
    chk("R10 start wins", reg_rdata, 16'h0002);

    finished = 1;
    summary();
    $finish;
  end
endmodule